// File: doc/BRIEF.md
# Two-Function Register Cell Array

This block is a register of parameterised width built from identical one-bit cells. On every rising clock edge the register either keeps its contents, takes the bitwise OR of its own value with a data word, or takes the bitwise exclusive-OR of its own value with that word. Two separate control lines, one for the OR transfer and one for the exclusive-OR transfer, choose the operation. When both lines are low the register holds.

Each cell computes its next value from one minimized equation in its two control lines, its own stored bit and its own data bit. The flip-flops have no load enable, so holding is just the equation returning the stored bit. The equation also settles the case where both control lines are high: the OR transfer wins. A synchronous active-high reset clears the register to zero.

Top module: `regcell_array`

## Requirements
- R1: While rst is high at a rising clock edge, regA becomes all zeros after that edge, whatever orCtl, xorCtl and dataB are.
- R2: With orCtl = 0 and xorCtl = 0 at an edge, regA keeps its value after that edge.
- R3: With orCtl = 1 and xorCtl = 0 at an edge, regA becomes regA | dataB after that edge.
- R4: With orCtl = 0 and xorCtl = 1 at an edge, regA becomes regA ^ dataB after that edge. A bit with dataB = 0 keeps its value and a bit with dataB = 1 is complemented.
- R5: With orCtl = 1 and xorCtl = 1 at an edge, the OR transfer takes precedence and regA becomes regA | dataB.
- R6: Each bit i of regA depends only on bit i of regA and bit i of dataB and on the two control lines. A one in a single bit position of dataB changes no other bit. The width is the parameter WIDTH, default 8.
- R7: regA changes only at rising clock edges. Input changes between edges do not reach the output until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears regA |
| orCtl | input | 1 | Selects regA OR dataB; has priority |
| xorCtl | input | 1 | Selects regA XOR dataB |
| dataB | input | WIDTH | Data operand word |
| regA | output | WIDTH | Register contents |

## Verification
The assertions check on every cycle that the next register value matches the selected transfer for hold, OR, exclusive-OR and the both-high case, and that reset clears the register. The assertions cannot show that a bit stays independent of the other bit positions, or that the output stays stable when inputs change between edges. The bench scenarios show both with walking-one patterns and with inputs changed in mid-cycle. They also show longer operation sequences against a model kept in the bench.

// File: rtl/regcell_pkg.sv
package regcell_pkg;

  // Strobes sent by the control decoder to every bit cell.
  typedef struct packed {
    logic clear;
    logic orStrobe;
    logic xorStrobe;
  } cellCtrlT;

endpackage

// File: rtl/regcell_ctrl.sv
module regcell_ctrl
  import regcell_pkg::*;
(
  input  logic     rst,
  input  logic     orCtl,
  input  logic     xorCtl,
  output cellCtrlT ctrl
);

  // Precedence of OR over XOR comes from the cell equation itself,
  // so both strobes pass through without extra gating.
  always_comb begin
    ctrl.clear     = rst;
    ctrl.orStrobe  = orCtl;
    ctrl.xorStrobe = xorCtl;
  end

endmodule

// File: rtl/regcell_bit.sv
module regcell_bit
  import regcell_pkg::*;
(
  input  logic     clk,
  input  cellCtrlT ctrl,
  input  logic     bitB,
  output logic     bitA
);

  logic nextA;

  // Minimized cell equation: D = CX.B + (A xor CY.B)
  always_comb begin
    nextA = (ctrl.orStrobe & bitB) | (bitA ^ (ctrl.xorStrobe & bitB));
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) bitA <= 1'b0;
    else            bitA <= nextA;
  end

endmodule

// File: rtl/regcell_datapath.sv
module regcell_datapath
  import regcell_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  cellCtrlT         ctrl,
  input  logic [WIDTH-1:0] dataB,
  output logic [WIDTH-1:0] regA
);

  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i <= MSB; i++) begin : g_cell
    regcell_bit cell_i (
      .clk  (clk),
      .ctrl (ctrl),
      .bitB (dataB[i]),
      .bitA (regA[i])
    );
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (ctrl.clear)
    (!ctrl.orStrobe && !ctrl.xorStrobe) |=> regA == $past(regA))
    else $error("hold transfer broken");

  p_or_r3: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.orStrobe && !ctrl.xorStrobe) |=> regA == ($past(regA) | $past(dataB)))
    else $error("OR transfer broken");

  p_xor_r4: assert property (@(posedge clk) disable iff (ctrl.clear)
    (!ctrl.orStrobe && ctrl.xorStrobe) |=> regA == ($past(regA) ^ $past(dataB)))
    else $error("XOR transfer broken");

  p_both_r5: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.orStrobe && ctrl.xorStrobe) |=> regA == ($past(regA) | $past(dataB)))
    else $error("OR precedence broken");

endmodule

// File: rtl/regcell_array.sv
module regcell_array
  import regcell_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             orCtl,
  input  logic             xorCtl,
  input  logic [WIDTH-1:0] dataB,
  output logic [WIDTH-1:0] regA
);

  cellCtrlT ctrl;

  regcell_ctrl ctrl_i (
    .rst    (rst),
    .orCtl  (orCtl),
    .xorCtl (xorCtl),
    .ctrl   (ctrl)
  );

  regcell_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk   (clk),
    .ctrl  (ctrl),
    .dataB (dataB),
    .regA  (regA)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> regA == '0)
    else $error("reset did not clear register");

endmodule

// File: tb/regcell_array_tb_top.sv
module regcell_array_tb_top;

  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst;
  logic orCtl, xorCtl;
  logic [WIDTH-1:0] dataB;
  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  regcell_array #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .orCtl(orCtl), .xorCtl(xorCtl),
    .dataB(dataB), .regA(regA)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [WIDTH-1:0] exp);
    checks++;
    if (regA !== exp) begin
      errors++;
      $display("FAIL %s: regA=%h expected %h", tag, regA, exp);
    end
  endtask

  // Apply one edge with given controls, update model, check after edge.
  task automatic step(input string tag, input logic r, input logic cx,
                      input logic cy, input logic [WIDTH-1:0] b);
    @(negedge clk);
    rst = r; orCtl = cx; xorCtl = cy; dataB = b;
    if (r)       model = '0;
    else if (cx) model = model | b;
    else if (cy) model = model ^ b;
    @(posedge clk);
    #1;
    check(tag, model);
  endtask

  task automatic test_reset();
    step("R1 reset", 1, 0, 0, 8'hFF);
    step("R1 reset with controls", 1, 1, 1, 8'hA5);
  endtask

  task automatic test_hold();
    step("R3 setup", 0, 1, 0, 8'h5A);
    step("R2 hold B=FF", 0, 0, 0, 8'hFF);
    step("R2 hold B=00", 0, 0, 0, 8'h00);
  endtask

  task automatic test_or();
    step("R3 or 81", 0, 1, 0, 8'h81);
    step("R3 or 00", 0, 1, 0, 8'h00);
    step("R3 or FF", 0, 1, 0, 8'hFF);
  endtask

  task automatic test_xor();
    step("R4 xor 0F", 0, 0, 1, 8'h0F);
    step("R4 xor 00 keeps", 0, 0, 1, 8'h00);
    step("R4 xor FF complements", 0, 0, 1, 8'hFF);
    step("R4 xor 3C", 0, 0, 1, 8'h3C);
  endtask

  task automatic test_both();
    step("R1 clear", 1, 0, 0, 8'h00);
    step("R4 xor C3", 0, 0, 1, 8'hC3);
    step("R5 both high", 0, 1, 1, 8'h0F);
    step("R5 both high 2", 0, 1, 1, 8'hF0);
  endtask

  task automatic test_walk();
    step("R1 clear", 1, 0, 0, 8'h00);
    for (int i = 0; i < WIDTH; i++) begin
      step("R6 walk or", 0, 1, 0, WIDTH'(1) << i);
    end
    for (int i = 0; i < WIDTH; i++) begin
      step("R6 walk xor", 0, 0, 1, WIDTH'(1) << i);
    end
  endtask

  task automatic test_midcycle();
    step("R4 setup", 0, 0, 1, 8'h66);
    @(negedge clk);
    rst = 0; orCtl = 1; xorCtl = 0; dataB = 8'hFF;
    #2;
    check("R7 no change before edge", model);
    dataB = 8'h10;
    model = model | 8'h10;
    @(posedge clk);
    #1;
    check("R7 value at edge", model);
  endtask

  initial begin
    rst = 1; orCtl = 0; xorCtl = 0; dataB = '0; model = '0;
    test_reset();
    test_hold();
    test_or();
    test_xor();
    test_both();
    test_walk();
    test_midcycle();
    step("R1 reset mid-run", 1, 0, 1, 8'hFF);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule